// File: doc/BRIEF.md
# Luma Threshold Coring Unit

This block cleans or sharpens a luma stream one sample at a time. Each sample arrives with two companions. The first is a band-filtered detail value taken from the same luma. The second is a flag that says whether the pixel lies on a block border or inside the block. The unit compares the magnitude of the detail value with a programmable threshold. It then picks which part of the detail to act on, scales that part by the gain set for the pixel's region, and folds the result back into the original sample.

The unit has two operating modes, chosen by a single control bit, and the mode decides both the direction and the step size:

- **Smoothing (mode 0):** small detail is treated as noise and removed.
- **Sharpening (mode 1):** large detail is treated as real picture content and boosted.

A valid strobe travels with the data through a two-stage pipeline. The control fields are captured together with each sample, so a mode or gain change takes effect on exactly the sample that arrives with it. The unit has no state machine. Its only modal state is the mode bit (`MODE_SMOOTH`, `MODE_SHARPEN`), which is registered per sample, and the region (`REGION_DATA`, `REGION_BORDER`), which is taken per sample from the flag. Nothing moves from one state to another inside the block.

Top module: `luma_coring_unit`

## Requirements
- R1: While `rst_n` is low, `out_valid` and `out_luma` are 0.
- R2: `out_valid` repeats `in_valid` exactly two clock edges later, and `out_luma` belongs to the sample accepted at that same earlier edge.
- R3: A detail magnitude |`in_detail`| that is greater than or equal to `cfg_threshold` counts as above the threshold. Equality therefore counts as above.
- R4: With `cfg_sharpen`=0, a below-threshold detail is scaled and subtracted from `in_luma`. An above-threshold detail leaves `in_luma` unchanged.
- R5: With `cfg_sharpen`=1, an above-threshold detail is scaled and added to `in_luma`. A below-threshold detail leaves `in_luma` unchanged.
- R6: In smoothing mode a gain code c means min(c,8)/8. Codes 9 to 15 act as a gain of 1.
- R7: In sharpening mode a gain code c means min(c,8)/16. Codes 9 to 15 act as a gain of 1/2.
- R8: `in_border`=1 selects `cfg_gain_border`, and `in_border`=0 selects `cfg_gain_data`.
- R9: The result is clamped to 0..1023 after the add or the subtract.
- R10: The scaled term equals floor(detail × n / 16), rounded toward minus infinity. Here n is 2·min(c,8) in smoothing mode and min(c,8) in sharpening mode.
- R11: A cycle with `in_valid`=0 leaves `out_luma` unchanged two edges later, whatever the other inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Sample strobe |
| in_luma | input | 10 | Original luma, unsigned |
| in_detail | input | 11 | Band-filtered detail, two's complement |
| in_border | input | 1 | 1 = border pixel, 0 = data pixel |
| cfg_threshold | input | 6 | Magnitude threshold, 0..63 |
| cfg_gain_border | input | 4 | Gain code for border pixels |
| cfg_gain_data | input | 4 | Gain code for data pixels |
| cfg_sharpen | input | 1 | 0 = smoothing mode, 1 = sharpening mode |
| out_valid | output | 1 | Result strobe |
| out_luma | output | 10 | Processed luma |

## Verification
Three things can land in the same cycle: the threshold decision, the switch between modes, and the saturating clamp. A sample that sits exactly on the threshold can arrive on the cycle the mode bit flips, carrying a detail large enough to push the result past 0 or 1023.

The random phase toggles mode, region and gains on every sample. Directed samples place the magnitude exactly at the threshold next to a saturating clamp. A bench model computes each expected output from that sample's own control values, so a result built with a stale mode or gain is reported.

// File: rtl/coring_pkg.sv
package coring_pkg;

    typedef enum logic {
        MODE_SMOOTH  = 1'b0,
        MODE_SHARPEN = 1'b1
    } core_mode_e;

    typedef enum logic {
        REGION_DATA   = 1'b0,
        REGION_BORDER = 1'b1
    } region_e;

endpackage

// File: rtl/coring_classify.sv
module coring_classify
    import coring_pkg::*;
#(
    parameter int DETAIL_W = 11,
    parameter int THR_W    = 6,
    parameter int GAIN_W   = 4,
    localparam int NUM_W   = GAIN_W + 1
) (
    input  logic signed [DETAIL_W-1:0] detail,
    input  logic        [THR_W-1:0]    threshold,
    input  logic        [GAIN_W-1:0]   gain_border,
    input  logic        [GAIN_W-1:0]   gain_data,
    input  region_e                    region,
    input  core_mode_e                 mode,
    output logic                       selected,
    output logic        [NUM_W-1:0]    gain_num
);

    localparam logic [DETAIL_W-1:0] ONE      = DETAIL_W'(1);
    localparam logic [GAIN_W-1:0]   CAP_CODE = GAIN_W'(1 << (GAIN_W - 1));

    logic [DETAIL_W-1:0] raw;
    logic [DETAIL_W-1:0] mag;
    logic [DETAIL_W-1:0] thr_ext;
    logic                above;
    logic [GAIN_W-1:0]   code;
    logic [GAIN_W-1:0]   capped;

    always_comb begin
        raw     = detail;
        mag     = raw[DETAIL_W-1] ? (~raw + ONE) : raw;
        thr_ext = {{(DETAIL_W - THR_W){1'b0}}, threshold};
        above   = (mag >= thr_ext);
    end

    always_comb begin
        unique case (region)
            REGION_BORDER: code = gain_border;
            REGION_DATA:   code = gain_data;
            default:       code = gain_data;
        endcase
        capped = (code > CAP_CODE) ? CAP_CODE : code;
    end

    always_comb begin
        unique case (mode)
            MODE_SHARPEN: begin
                selected = above;
                gain_num = {1'b0, capped};
            end
            MODE_SMOOTH: begin
                selected = !above;
                gain_num = {capped, 1'b0};
            end
            default: begin
                selected = 1'b0;
                gain_num = '0;
            end
        endcase
    end

    always_comb begin
        if (mag == thr_ext) begin
            assert_equal_is_above_R3: assert (selected == (mode == MODE_SHARPEN))
                else $error("threshold equality not treated as above");
        end
    end

endmodule

// File: rtl/coring_apply.sv
module coring_apply
    import coring_pkg::*;
#(
    parameter int LUMA_W   = 10,
    parameter int DETAIL_W = 11,
    parameter int GAIN_W   = 4,
    localparam int NUM_W   = GAIN_W + 1,
    localparam int PROD_W  = DETAIL_W + NUM_W + 1
) (
    input  logic        [LUMA_W-1:0]   luma,
    input  logic signed [DETAIL_W-1:0] detail,
    input  logic                       selected,
    input  logic        [NUM_W-1:0]    gain_num,
    input  core_mode_e                 mode,
    output logic        [LUMA_W-1:0]   result
);

    localparam logic signed [PROD_W-1:0] LUMA_MAX = PROD_W'((1 << LUMA_W) - 1);

    logic signed [PROD_W-1:0] d_ext;
    logic signed [PROD_W-1:0] g_ext;
    logic signed [PROD_W-1:0] l_ext;
    logic signed [PROD_W-1:0] prod;
    logic signed [PROD_W-1:0] scaled;
    logic signed [PROD_W-1:0] delta;
    logic signed [PROD_W-1:0] sum;

    always_comb begin
        d_ext  = PROD_W'(detail);
        g_ext  = PROD_W'(gain_num);
        l_ext  = PROD_W'(luma);
        prod   = d_ext * g_ext;
        scaled = prod >>> GAIN_W;
        delta  = selected ? scaled : '0;
    end

    always_comb begin
        unique case (mode)
            MODE_SHARPEN: sum = l_ext + delta;
            MODE_SMOOTH:  sum = l_ext - delta;
            default:      sum = l_ext;
        endcase
        if (sum < 0)
            result = '0;
        else if (sum > LUMA_MAX)
            result = LUMA_MAX[LUMA_W-1:0];
        else
            result = sum[LUMA_W-1:0];
    end

    always_comb begin
        if (!selected) begin
            assert_unselected_pass_R4: assert (result == luma)
                else $error("unselected sample altered");
        end
        if (selected && mode == MODE_SHARPEN && !detail[DETAIL_W-1]) begin
            assert_sharpen_raises_R5: assert (result >= luma)
                else $error("sharpening lowered a positive detail");
        end
        if (selected && mode == MODE_SMOOTH && !detail[DETAIL_W-1]) begin
            assert_smooth_lowers_R4: assert (result <= luma)
                else $error("smoothing raised a positive detail");
        end
    end

endmodule

// File: rtl/luma_coring_unit.sv
module luma_coring_unit
    import coring_pkg::*;
#(
    parameter int LUMA_W   = 10,
    parameter int DETAIL_W = 11,
    parameter int THR_W    = 6,
    parameter int GAIN_W   = 4,
    localparam int NUM_W   = GAIN_W + 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    input  logic        [LUMA_W-1:0]   in_luma,
    input  logic signed [DETAIL_W-1:0] in_detail,
    input  logic                       in_border,
    input  logic        [THR_W-1:0]    cfg_threshold,
    input  logic        [GAIN_W-1:0]   cfg_gain_border,
    input  logic        [GAIN_W-1:0]   cfg_gain_data,
    input  logic                       cfg_sharpen,
    output logic                       out_valid,
    output logic        [LUMA_W-1:0]   out_luma
);

    core_mode_e mode_in;
    region_e    region_in;
    logic             sel_c;
    logic [NUM_W-1:0] num_c;

    assign mode_in   = cfg_sharpen ? MODE_SHARPEN : MODE_SMOOTH;
    assign region_in = in_border ? REGION_BORDER : REGION_DATA;

    coring_classify #(
        .DETAIL_W (DETAIL_W),
        .THR_W    (THR_W),
        .GAIN_W   (GAIN_W)
    ) u_classify (
        .detail      (in_detail),
        .threshold   (cfg_threshold),
        .gain_border (cfg_gain_border),
        .gain_data   (cfg_gain_data),
        .region      (region_in),
        .mode        (mode_in),
        .selected    (sel_c),
        .gain_num    (num_c)
    );

    logic                       s1_valid;
    logic        [LUMA_W-1:0]   s1_luma;
    logic signed [DETAIL_W-1:0] s1_detail;
    logic                       s1_sel;
    logic        [NUM_W-1:0]    s1_num;
    core_mode_e                 s1_mode;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_valid  <= 1'b0;
            s1_luma   <= '0;
            s1_detail <= '0;
            s1_sel    <= 1'b0;
            s1_num    <= '0;
            s1_mode   <= MODE_SMOOTH;
        end else begin
            s1_valid <= in_valid;
            if (in_valid) begin
                s1_luma   <= in_luma;
                s1_detail <= in_detail;
                s1_sel    <= sel_c;
                s1_num    <= num_c;
                s1_mode   <= mode_in;
            end
        end
    end

    logic [LUMA_W-1:0] res_c;

    coring_apply #(
        .LUMA_W   (LUMA_W),
        .DETAIL_W (DETAIL_W),
        .GAIN_W   (GAIN_W)
    ) u_apply (
        .luma     (s1_luma),
        .detail   (s1_detail),
        .selected (s1_sel),
        .gain_num (s1_num),
        .mode     (s1_mode),
        .result   (res_c)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_luma  <= '0;
        end else begin
            out_valid <= s1_valid;
            if (s1_valid)
                out_luma <= res_c;
        end
    end

    // Checker state for the latency and hold properties
    logic [1:0] since_rst;
    logic       iv_d1, iv_d2;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_rst <= '0;
            iv_d1     <= 1'b0;
            iv_d2     <= 1'b0;
        end else begin
            if (since_rst != 2'd2)
                since_rst <= since_rst + 2'd1;
            iv_d1 <= in_valid;
            iv_d2 <= iv_d1;
        end
    end

    assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd2) |-> (out_valid == iv_d2))
        else $error("valid strobe latency mismatch");

    assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!s1_valid) |=> $stable(out_luma))
        else $error("output changed on an idle slot");

    assert_reset_clear_R1: assert property (@(posedge clk)
        (!rst_n) |-> (!out_valid && out_luma == '0))
        else $error("outputs not clear in reset");

endmodule

// File: tb/luma_coring_unit_bench.sv
module luma_coring_unit_bench;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic [9:0]        in_luma = '0;
    logic signed [10:0] in_detail = '0;
    logic              in_border = 1'b0;
    logic [5:0]        cfg_threshold = '0;
    logic [3:0]        cfg_gain_border = '0;
    logic [3:0]        cfg_gain_data = '0;
    logic              cfg_sharpen = 1'b0;
    logic              out_valid;
    logic [9:0]        out_luma;

    always #2 clk = ~clk;

    luma_coring_unit u_luma_coring_unit (
        .clk             (clk),
        .rst_n           (rst_n),
        .in_valid        (in_valid),
        .in_luma         (in_luma),
        .in_detail       (in_detail),
        .in_border       (in_border),
        .cfg_threshold   (cfg_threshold),
        .cfg_gain_border (cfg_gain_border),
        .cfg_gain_data   (cfg_gain_data),
        .cfg_sharpen     (cfg_sharpen),
        .out_valid       (out_valid),
        .out_luma        (out_luma)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic  p1_v = 1'b0, p2_v = 1'b0;
    int    p1_exp = 0, p2_exp = 0;
    string p1_tag = "R2", p2_tag = "R2";
    int    last_exp = 0;

    function automatic int model(int luma, int det, bit border, int thr,
                                 int gb, int gd, bit sharp);
        int mag, c, num, prod, sc, res;
        bit above, sel;
        mag   = (det < 0) ? -det : det;
        above = (mag >= thr);
        c     = border ? gb : gd;
        if (c > 8) c = 8;
        num   = sharp ? c : 2 * c;
        sel   = sharp ? above : !above;
        if (!sel) return luma;
        prod  = det * num;
        sc    = prod >>> 4;
        res   = sharp ? luma + sc : luma - sc;
        if (res < 0) res = 0;
        if (res > 1023) res = 1023;
        return res;
    endfunction

    task automatic check(bit cond, string tag, int act, int exp);
        checks++;
        if (!cond) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(bit v, int luma, int det, bit border, int thr,
                        int gb, int gd, bit sharp, string tag);
        @(negedge clk);
        check(out_valid == p2_v, "R2 valid", int'(out_valid), int'(p2_v));
        if (p2_v) begin
            check(int'(out_luma) == p2_exp, p2_tag, int'(out_luma), p2_exp);
            last_exp = p2_exp;
        end else begin
            check(int'(out_luma) == last_exp, "R11 hold", int'(out_luma), last_exp);
        end
        p2_v = p1_v; p2_exp = p1_exp; p2_tag = p1_tag;
        p1_v = v;
        p1_exp = model(luma, det, border, thr, gb, gd, sharp);
        p1_tag = tag;
        in_valid        = v;
        in_luma         = 10'(luma);
        in_detail       = 11'(det);
        in_border       = border;
        cfg_threshold   = 6'(thr);
        cfg_gain_border = 4'(gb);
        cfg_gain_data   = 4'(gd);
        cfg_sharpen     = sharp;
    endtask

    initial begin
        #(4 * 100000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R1 valid", int'(out_valid), 0);
        check(out_luma == 10'd0, "R1 luma", int'(out_luma), 0);
        rst_n = 1'b1;

        // R3: equality counts as above
        step(1, 500, 20, 0, 20, 0, 8, 0, "R3 smooth eq");
        step(1, 500, -20, 0, 20, 0, 8, 1, "R3 sharpen eq");
        // R4: smoothing below and above threshold
        step(1, 500, 19, 0, 20, 0, 8, 0, "R4 below");
        step(1, 500, 40, 0, 20, 0, 8, 0, "R4 above");
        // R5: sharpening below and above
        step(1, 300, 10, 0, 20, 0, 8, 1, "R5 below");
        step(1, 300, 100, 0, 20, 0, 4, 1, "R5 above");
        // R6: code 12 saturates to gain 1
        step(1, 600, 33, 0, 63, 0, 12, 0, "R6 sat");
        step(1, 600, 33, 0, 63, 0, 3, 0, "R6 step");
        // R7: code 15 saturates to gain 1/2
        step(1, 200, 200, 0, 5, 0, 15, 1, "R7 sat");
        step(1, 200, 200, 0, 5, 0, 5, 1, "R7 step");
        // R8: region picks the gain
        step(1, 400, 30, 1, 63, 0, 8, 0, "R8 border");
        step(1, 400, 30, 0, 63, 0, 8, 0, "R8 data");
        step(1, 400, 30, 1, 63, 8, 0, 0, "R8 border2");
        // R9: clamp both ends
        step(1, 1020, 500, 0, 5, 0, 8, 1, "R9 high");
        step(1, 5, 40, 0, 63, 8, 8, 0, "R9 low");
        step(1, 1015, -40, 1, 63, 8, 0, 0, "R9 high smooth");
        // R10: floor toward minus infinity
        step(1, 100, -7, 0, 63, 0, 1, 0, "R10 neg");
        step(1, 100, 7, 0, 63, 0, 1, 0, "R10 pos");
        step(1, 100, -1024, 0, 0, 0, 1, 1, "R10 min");
        // R11: idle slots ignore their data
        step(0, 1023, 900, 1, 0, 15, 15, 1, "R11");
        step(0, 0, -900, 0, 63, 15, 15, 0, "R11");
        step(1, 777, 3, 0, 63, 0, 8, 0, "R11 resume");

        for (int i = 0; i < 3000; i++) begin
            int  det, thr;
            bit  v, sh;
            v   = ($urandom_range(0, 9) < 8);
            sh  = $urandom_range(0, 1) == 1;
            thr = $urandom_range(0, 63);
            det = $urandom_range(0, 7) == 0 ? (thr * (($urandom_range(0, 1) == 1) ? 1 : -1))
                                            : int'($urandom_range(0, 2047)) - 1024;
            step(v, $urandom_range(0, 1023), det, $urandom_range(0, 1) == 1, thr,
                 $urandom_range(0, 15), $urandom_range(0, 15), sh,
                 sh ? "R5 random" : "R4 random");
        end
        step(0, 0, 0, 0, 0, 0, 0, 0, "R2");
        step(0, 0, 0, 0, 0, 0, 0, 0, "R2");
        step(0, 0, 0, 0, 0, 0, 0, 0, "R2");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule